// File: doc/BRIEF.md
# Floating-Point Register Rename Status Table

This block holds the architectural floating-point register values of a dynamically scheduled core, together with a producer tag for each register. A producer tag names the reservation station whose result will next be written to that register; the tag value zero is reserved and means no station is pending, so the stored value is current.

When an instruction issues, the two source ports report for each named register either its value (ready) or the tag of the station that will produce it. In the same cycle the destination register is renamed: its producer tag is overwritten with the issuing station's tag, whether or not an older producer is still outstanding. When a station broadcasts a result, every register whose producer tag equals the broadcast tag takes the value and returns to the no-producer state. A register renamed again in the meantime ignores the older station's result. This is what removes write-after-write and write-after-read hazards without any comparison logic between instructions.

Source reads are combinational and see a broadcast that arrives in the same cycle. The rename is applied at the clock edge, so an instruction whose source and destination name the same register reads the older state.

Top module: `fp_rename_table`

## Requirements
- R1: While reset is asserted, and after it, every register holds value zero and producer tag zero (no producer); a read of any register then reports ready with value zero.
- R2: A source port naming a register whose producer tag is zero reports ready=1, the stored value, and tag 0.
- R3: A source port naming a register with a nonzero producer tag that is not being broadcast this cycle reports ready=0, tag equal to the producer tag, and value 0.
- R4: With iss_valid=1, the destination register's producer tag becomes iss_dst_tag at the clock edge, replacing any older pending tag. With iss_valid=0, the destination and tag inputs have no effect.
- R5: A broadcast (bc_valid=1) whose tag equals a register's nonzero producer tag writes bc_data into that register and clears its producer tag to zero at the clock edge.
- R6: A broadcast whose tag differs from a register's producer tag leaves that register's value and tag unchanged.
- R7: A source port naming a register whose nonzero producer tag equals the tag broadcast in the same cycle reports ready=1, value bc_data and tag 0 in that cycle.
- R8: When a source and the destination of an issuing instruction name the same register, the source port reports the register's state from before the rename.
- R9: When a register's matching broadcast and its rename occur in the same cycle, the register's producer tag afterwards is the new issue tag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| iss_valid | input | 1 | An instruction issues this cycle |
| iss_src_a_idx | input | 2 | Register index for source port A |
| iss_src_b_idx | input | 2 | Register index for source port B |
| iss_dst_idx | input | 2 | Destination register to rename |
| iss_dst_tag | input | 3 | Tag of the issuing station (nonzero) |
| bc_valid | input | 1 | A result is broadcast this cycle |
| bc_tag | input | 3 | Tag of the broadcasting station (nonzero) |
| bc_data | input | 32 | Broadcast result value |
| src_a_ready | output | 1 | Source A value is available |
| src_a_value | output | 32 | Source A value, zero when not ready |
| src_a_tag | output | 3 | Source A producer tag, zero when ready |
| src_b_ready | output | 1 | Source B value is available |
| src_b_value | output | 32 | Source B value, zero when not ready |
| src_b_tag | output | 3 | Source B producer tag, zero when ready |

## Verification
The assertions take for granted that the issue tag and the broadcast tag are never zero while their valid bits are high, and that no two registers wait on the same tag except where the surrounding scheduler intends it; one input assertion guards the issue tag. The stimulus gives each in-flight station a distinct nonzero tag and only reuses a tag after its broadcast has retired it. Stale broadcasts, same-cycle rename and broadcast, and a broadcast of a tag that no register holds are all driven on purpose so that R6, R7 and R9 are reached.

// File: rtl/fp_rename_pkg.sv
package fp_rename_pkg;
    localparam int DEF_NREG   = 4;
    localparam int DEF_DATA_W = 32;
    localparam int DEF_TAG_W  = 3;

    // Tag value zero is the "no producer" marker.
    function automatic logic tag_is_live(input logic [7:0] t);
        return t != 8'd0;
    endfunction
endpackage

// File: rtl/fp_rename_entry.sv
module fp_rename_entry #(
    parameter int DATA_W = fp_rename_pkg::DEF_DATA_W,
    parameter int TAG_W  = fp_rename_pkg::DEF_TAG_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rename_en,
    input  logic [TAG_W-1:0]  rename_tag,
    input  logic              bc_valid,
    input  logic [TAG_W-1:0]  bc_tag,
    input  logic [DATA_W-1:0] bc_data,
    output logic [TAG_W-1:0]  tag_o,
    output logic [DATA_W-1:0] val_o
);
    typedef struct packed {
        logic [TAG_W-1:0]  tag;
        logic [DATA_W-1:0] val;
    } entry_t;

    entry_t ent_d, ent_q;
    logic   bc_hit;

    always_comb begin
        ent_d  = ent_q;
        bc_hit = bc_valid && (ent_q.tag != '0) && (ent_q.tag == bc_tag);
        if (bc_hit) begin
            ent_d.val = bc_data;
            ent_d.tag = '0;
        end
        // A newer producer takes priority over the completing one.
        if (rename_en) begin
            ent_d.tag = rename_tag;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ent_q <= '0;
        end else begin
            ent_q <= ent_d;
        end
    end

    assign tag_o = ent_q.tag;
    assign val_o = ent_q.val;
endmodule

// File: rtl/fp_rename_rdport.sv
module fp_rename_rdport #(
    parameter int NREG   = fp_rename_pkg::DEF_NREG,
    parameter int DATA_W = fp_rename_pkg::DEF_DATA_W,
    parameter int TAG_W  = fp_rename_pkg::DEF_TAG_W,
    localparam int IDX_W = (NREG > 1) ? $clog2(NREG) : 1
) (
    input  logic [IDX_W-1:0]             idx,
    input  logic [NREG-1:0][TAG_W-1:0]   tags,
    input  logic [NREG-1:0][DATA_W-1:0]  vals,
    input  logic                         bc_valid,
    input  logic [TAG_W-1:0]             bc_tag,
    input  logic [DATA_W-1:0]            bc_data,
    output logic                         ready,
    output logic [DATA_W-1:0]            value,
    output logic [TAG_W-1:0]             tag
);
    logic [TAG_W-1:0]  cur_tag;
    logic [DATA_W-1:0] cur_val;

    always_comb begin
        cur_tag = tags[idx];
        cur_val = vals[idx];
        if (cur_tag == '0) begin
            ready = 1'b1;
            value = cur_val;
            tag   = '0;
        end else if (bc_valid && (bc_tag == cur_tag)) begin
            ready = 1'b1;
            value = bc_data;
            tag   = '0;
        end else begin
            ready = 1'b0;
            value = '0;
            tag   = cur_tag;
        end
    end
endmodule

// File: rtl/fp_rename_table.sv
module fp_rename_table #(
    parameter int NREG   = fp_rename_pkg::DEF_NREG,
    parameter int DATA_W = fp_rename_pkg::DEF_DATA_W,
    parameter int TAG_W  = fp_rename_pkg::DEF_TAG_W,
    localparam int IDX_W = (NREG > 1) ? $clog2(NREG) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              iss_valid,
    input  logic [IDX_W-1:0]  iss_src_a_idx,
    input  logic [IDX_W-1:0]  iss_src_b_idx,
    input  logic [IDX_W-1:0]  iss_dst_idx,
    input  logic [TAG_W-1:0]  iss_dst_tag,
    input  logic              bc_valid,
    input  logic [TAG_W-1:0]  bc_tag,
    input  logic [DATA_W-1:0] bc_data,
    output logic              src_a_ready,
    output logic [DATA_W-1:0] src_a_value,
    output logic [TAG_W-1:0]  src_a_tag,
    output logic              src_b_ready,
    output logic [DATA_W-1:0] src_b_value,
    output logic [TAG_W-1:0]  src_b_tag
);
    logic [NREG-1:0][TAG_W-1:0]  tag_q;
    logic [NREG-1:0][DATA_W-1:0] val_q;
    logic [NREG-1:0]             rename_sel;

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        assign rename_sel[g] = iss_valid && (iss_dst_idx == IDX_W'(g));

        fp_rename_entry #(
            .DATA_W (DATA_W),
            .TAG_W  (TAG_W)
        ) u_entry (
            .clk        (clk),
            .rst_n      (rst_n),
            .rename_en  (rename_sel[g]),
            .rename_tag (iss_dst_tag),
            .bc_valid   (bc_valid),
            .bc_tag     (bc_tag),
            .bc_data    (bc_data),
            .tag_o      (tag_q[g]),
            .val_o      (val_q[g])
        );
    end

    fp_rename_rdport #(
        .NREG (NREG), .DATA_W (DATA_W), .TAG_W (TAG_W)
    ) u_rd_a (
        .idx      (iss_src_a_idx),
        .tags     (tag_q),
        .vals     (val_q),
        .bc_valid (bc_valid),
        .bc_tag   (bc_tag),
        .bc_data  (bc_data),
        .ready    (src_a_ready),
        .value    (src_a_value),
        .tag      (src_a_tag)
    );

    fp_rename_rdport #(
        .NREG (NREG), .DATA_W (DATA_W), .TAG_W (TAG_W)
    ) u_rd_b (
        .idx      (iss_src_b_idx),
        .tags     (tag_q),
        .vals     (val_q),
        .bc_valid (bc_valid),
        .bc_tag   (bc_tag),
        .bc_data  (bc_data),
        .ready    (src_b_ready),
        .value    (src_b_value),
        .tag      (src_b_tag)
    );
endmodule

// File: rtl/fp_rename_table_chk.sv
module fp_rename_table_chk #(
    parameter int NREG   = 4,
    parameter int DATA_W = 32,
    parameter int TAG_W  = 3,
    localparam int IDX_W = (NREG > 1) ? $clog2(NREG) : 1
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        iss_valid,
    input logic [IDX_W-1:0]            iss_src_a_idx,
    input logic [IDX_W-1:0]            iss_dst_idx,
    input logic [TAG_W-1:0]            iss_dst_tag,
    input logic                        bc_valid,
    input logic [TAG_W-1:0]            bc_tag,
    input logic [DATA_W-1:0]           bc_data,
    input logic                        src_a_ready,
    input logic [DATA_W-1:0]           src_a_value,
    input logic [TAG_W-1:0]            src_a_tag,
    input logic [NREG-1:0][TAG_W-1:0]  tag_q,
    input logic [NREG-1:0][DATA_W-1:0] val_q
);
    a_in_issue_tag_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        iss_valid |-> iss_dst_tag != '0);

    // R3: pending register without a matching broadcast is reported as waiting
    a_r3_pending_reports_tag: assert property (@(posedge clk) disable iff (!rst_n)
        (tag_q[iss_src_a_idx] != '0 && !(bc_valid && bc_tag == tag_q[iss_src_a_idx]))
        |-> (!src_a_ready && src_a_tag == tag_q[iss_src_a_idx] && src_a_value == '0));

    // R7: same-cycle broadcast is forwarded to the source port
    a_r7_bypass: assert property (@(posedge clk) disable iff (!rst_n)
        (tag_q[iss_src_a_idx] != '0 && bc_valid && bc_tag == tag_q[iss_src_a_idx])
        |-> (src_a_ready && src_a_value == bc_data && src_a_tag == '0));

    for (genvar g = 0; g < NREG; g++) begin : g_chk
        // R4 and R9: rename always installs the new tag
        a_r4_rename_sets_tag: assert property (@(posedge clk) disable iff (!rst_n)
            (iss_valid && iss_dst_idx == IDX_W'(g)) |=> tag_q[g] == $past(iss_dst_tag));

        // R5: matching broadcast retires the producer and writes the value
        a_r5_match_writes: assert property (@(posedge clk) disable iff (!rst_n)
            (bc_valid && tag_q[g] != '0 && tag_q[g] == bc_tag
             && !(iss_valid && iss_dst_idx == IDX_W'(g)))
            |=> (tag_q[g] == '0 && val_q[g] == $past(bc_data)));

        // R6: anything else leaves the register alone
        a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
            (!(iss_valid && iss_dst_idx == IDX_W'(g))
             && !(bc_valid && tag_q[g] != '0 && tag_q[g] == bc_tag))
            |=> ($stable(tag_q[g]) && $stable(val_q[g])));
    end
endmodule

bind fp_rename_table fp_rename_table_chk #(
    .NREG (NREG), .DATA_W (DATA_W), .TAG_W (TAG_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .iss_valid     (iss_valid),
    .iss_src_a_idx (iss_src_a_idx),
    .iss_dst_idx   (iss_dst_idx),
    .iss_dst_tag   (iss_dst_tag),
    .bc_valid      (bc_valid),
    .bc_tag        (bc_tag),
    .bc_data       (bc_data),
    .src_a_ready   (src_a_ready),
    .src_a_value   (src_a_value),
    .src_a_tag     (src_a_tag),
    .tag_q         (tag_q),
    .val_q         (val_q)
);

// File: tb/fp_rename_table_tb.sv
`timescale 1ns/1ps
module fp_rename_table_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        iss_valid = 1'b0;
    logic [1:0]  iss_src_a_idx = '0, iss_src_b_idx = '0, iss_dst_idx = '0;
    logic [2:0]  iss_dst_tag = '0;
    logic        bc_valid = 1'b0;
    logic [2:0]  bc_tag = '0;
    logic [31:0] bc_data = '0;
    logic        src_a_ready, src_b_ready;
    logic [31:0] src_a_value, src_b_value;
    logic [2:0]  src_a_tag, src_b_tag;

    int n_vec = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    fp_rename_table u_dut (
        .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid),
        .iss_src_a_idx(iss_src_a_idx), .iss_src_b_idx(iss_src_b_idx),
        .iss_dst_idx(iss_dst_idx), .iss_dst_tag(iss_dst_tag),
        .bc_valid(bc_valid), .bc_tag(bc_tag), .bc_data(bc_data),
        .src_a_ready(src_a_ready), .src_a_value(src_a_value), .src_a_tag(src_a_tag),
        .src_b_ready(src_b_ready), .src_b_value(src_b_value), .src_b_tag(src_b_tag)
    );

    typedef struct packed {
        logic        iv;
        logic [1:0]  sa;
        logic [1:0]  sb;
        logic [1:0]  dst;
        logic [2:0]  tg;
        logic        bv;
        logic [2:0]  bt;
        logic [31:0] bd;
        logic        ar;
        logic [31:0] av;
        logic [2:0]  at;
        logic        br;
        logic [31:0] bvl;
        logic [2:0]  btg;
        logic [3:0]  rq;
    } vec_t;

    localparam int NV = 22;
    localparam vec_t VEC [NV] = '{
        '{1'b0,2'd0,2'd3,2'd0,3'd0,1'b0,3'd0,32'h0,  1'b1,32'h0,3'd0,  1'b1,32'h0,3'd0,  4'd2}, // R2
        '{1'b1,2'd1,2'd2,2'd1,3'd5,1'b0,3'd0,32'h0,  1'b1,32'h0,3'd0,  1'b1,32'h0,3'd0,  4'd8}, // R8
        '{1'b0,2'd1,2'd1,2'd0,3'd0,1'b0,3'd0,32'h0,  1'b0,32'h0,3'd5,  1'b0,32'h0,3'd5,  4'd3}, // R3
        '{1'b0,2'd1,2'd0,2'd0,3'd0,1'b1,3'd5,32'h11, 1'b1,32'h11,3'd0, 1'b1,32'h0,3'd0,  4'd7}, // R7
        '{1'b1,2'd1,2'd1,2'd1,3'd2,1'b0,3'd0,32'h0,  1'b1,32'h11,3'd0, 1'b1,32'h11,3'd0, 4'd5}, // R5
        '{1'b1,2'd1,2'd1,2'd1,3'd3,1'b0,3'd0,32'h0,  1'b0,32'h0,3'd2,  1'b0,32'h0,3'd2,  4'd4}, // R4
        '{1'b0,2'd1,2'd1,2'd0,3'd0,1'b1,3'd2,32'h22, 1'b0,32'h0,3'd3,  1'b0,32'h0,3'd3,  4'd6}, // R6
        '{1'b0,2'd1,2'd1,2'd0,3'd0,1'b0,3'd0,32'h0,  1'b0,32'h0,3'd3,  1'b0,32'h0,3'd3,  4'd6}, // R6
        '{1'b1,2'd1,2'd2,2'd1,3'd4,1'b1,3'd3,32'h33, 1'b1,32'h33,3'd0, 1'b1,32'h0,3'd0,  4'd7}, // R7
        '{1'b0,2'd1,2'd1,2'd0,3'd0,1'b0,3'd0,32'h0,  1'b0,32'h0,3'd4,  1'b0,32'h0,3'd4,  4'd9}, // R9
        '{1'b0,2'd1,2'd3,2'd0,3'd0,1'b1,3'd4,32'h44, 1'b1,32'h44,3'd0, 1'b1,32'h0,3'd0,  4'd7}, // R7
        '{1'b0,2'd1,2'd1,2'd0,3'd0,1'b0,3'd0,32'h0,  1'b1,32'h44,3'd0, 1'b1,32'h44,3'd0, 4'd5}, // R5
        '{1'b1,2'd2,2'd2,2'd2,3'd6,1'b0,3'd0,32'h0,  1'b1,32'h0,3'd0,  1'b1,32'h0,3'd0,  4'd8}, // R8
        '{1'b1,2'd2,2'd3,2'd3,3'd7,1'b0,3'd0,32'h0,  1'b0,32'h0,3'd6,  1'b1,32'h0,3'd0,  4'd3}, // R3
        '{1'b0,2'd2,2'd3,2'd0,3'd0,1'b1,3'd7,32'h77, 1'b0,32'h0,3'd6,  1'b1,32'h77,3'd0, 4'd7}, // R7
        '{1'b0,2'd2,2'd3,2'd0,3'd0,1'b1,3'd6,32'h66, 1'b1,32'h66,3'd0, 1'b1,32'h77,3'd0, 4'd7}, // R7
        '{1'b0,2'd2,2'd3,2'd0,3'd0,1'b0,3'd0,32'h0,  1'b1,32'h66,3'd0, 1'b1,32'h77,3'd0, 4'd5}, // R5
        '{1'b1,2'd0,2'd0,2'd0,3'd1,1'b0,3'd0,32'h0,  1'b1,32'h0,3'd0,  1'b1,32'h0,3'd0,  4'd8}, // R8
        '{1'b0,2'd0,2'd1,2'd0,3'd0,1'b1,3'd5,32'h99, 1'b0,32'h0,3'd1,  1'b1,32'h44,3'd0, 4'd6}, // R6
        '{1'b0,2'd0,2'd1,2'd0,3'd0,1'b0,3'd0,32'h0,  1'b0,32'h0,3'd1,  1'b1,32'h44,3'd0, 4'd6}, // R6
        '{1'b0,2'd2,2'd2,2'd2,3'd3,1'b0,3'd0,32'h0,  1'b1,32'h66,3'd0, 1'b1,32'h66,3'd0, 4'd4}, // R4
        '{1'b0,2'd2,2'd2,2'd0,3'd0,1'b0,3'd0,32'h0,  1'b1,32'h66,3'd0, 1'b1,32'h66,3'd0, 4'd4}  // R4
    };

    task automatic check_port(input string nm, input int rq,
                              input logic ar, input logic [31:0] av, input logic [2:0] at,
                              input logic er, input logic [31:0] ev, input logic [2:0] et);
        n_vec++;
        if (ar !== er || av !== ev || at !== et) begin
            n_bad++;
            $display("FAIL R%0d port %s: got ready=%0b value=%h tag=%0d, expected ready=%0b value=%h tag=%0d",
                     rq, nm, ar, av, at, er, ev, et);
        end
    endtask

    task automatic idle_inputs();
        iss_valid = 1'b0; iss_dst_idx = '0; iss_dst_tag = '0;
        bc_valid = 1'b0; bc_tag = '0; bc_data = '0;
    endtask

    // R1: read two registers at a time and expect the reset state
    task automatic check_reset_pair(input logic [1:0] ra, input logic [1:0] rb);
        @(negedge clk);
        idle_inputs();
        iss_src_a_idx = ra; iss_src_b_idx = rb;
        #1;
        check_port("A", 1, src_a_ready, src_a_value, src_a_tag, 1'b1, 32'h0, 3'd0);
        check_port("B", 1, src_b_ready, src_b_value, src_b_tag, 1'b1, 32'h0, 3'd0);
    endtask

    initial begin
        #(200000 * 5);
        n_bad++;
        $display("FAIL watchdog: got no completion, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check_reset_pair(2'd0, 2'd1);   // R1
        check_reset_pair(2'd2, 2'd3);   // R1

        for (int k = 0; k < NV; k++) begin
            @(negedge clk);
            iss_valid     = VEC[k].iv;
            iss_src_a_idx = VEC[k].sa;
            iss_src_b_idx = VEC[k].sb;
            iss_dst_idx   = VEC[k].dst;
            iss_dst_tag   = VEC[k].tg;
            bc_valid      = VEC[k].bv;
            bc_tag        = VEC[k].bt;
            bc_data       = VEC[k].bd;
            #1;
            check_port("A", int'(VEC[k].rq), src_a_ready, src_a_value, src_a_tag,
                       VEC[k].ar, VEC[k].av, VEC[k].at);
            check_port("B", int'(VEC[k].rq), src_b_ready, src_b_value, src_b_tag,
                       VEC[k].br, VEC[k].bvl, VEC[k].btg);
        end

        // R1: reset in mid-run clears pending tags (reg0) and values (reg1..3)
        @(negedge clk);
        idle_inputs();
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check_reset_pair(2'd0, 2'd1);
        check_reset_pair(2'd2, 2'd3);

        @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule